// File: doc/BRIEF.md
# Split-Tree Parallel-Prefix Adder

A purely combinational two-operand adder with a carry-in. Its carry network has two parts. The low part is a sparse, log-depth tree that sweeps up and then back down. The high part is a dense tree that reaches every bit at every level. The carry produced at the top of the low part enters the high part's tree as its carry-in, so the two parts together form one exact adder of `W` bits.

Both the total width `W` and the width `LO` of the low part are fixed at elaboration. Moving `LO` trades the low part's small node count against the high part's short depth. The block has no clock and no state. An instantiating design can register its ports wherever its timing calls for it.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: `sum` equals the low `W` bits of `a + b + cin`, computed as unsigned binary addition, for every operand value.
- R2: `cout` equals bit `W` (the carry out of the top bit) of `a + b + cin`.
- R3: The carry out of bit `LO-1` of the low part equals the carry of `a[LO-1:0] + b[LO-1:0] + cin`. Sums in the high part that depend on this carry come out correct.
- R4: `sum[LO-1:0]` depends only on `a[LO-1:0]`, `b[LO-1:0]` and `cin`. Changing any bit of the operands at or above position `LO` leaves these sum bits unchanged.
- R5: The adder builds and gives exact results at `W` = 8 and `W` = 16, with `LO` anywhere from 1 to `W-1`. An `LO` outside that range stops elaboration.
- R6: With `b` = 0 and `cin` = 0, `sum` equals `a` and `cout` is 0.
- R7: When `b` is the bitwise inverse of `a`, every bit propagates. With `cin` = 0, `sum` is all ones and `cout` is 0. With `cin` = 1, `sum` is 0 and `cout` is 1.
- R8: With `a` and `b` both all ones, `sum` is all ones with bit 0 equal to `cin`, and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First addend |
| b | input | W | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bench targets the cases where a carry has to cross the boundary between the two trees. Examples are a low part of all ones plus one, and operands where `b` is the inverse of `a`, so a single carry-in ripples through every bit. A design with a broken boundary link would give a high part that is one too small, with `cout` stuck low. A design with a missing down-sweep node would give wrong low-part sums at bit positions that are not one less than a power of two. These cases are run at the extreme splits `LO` = 1 and `LO` = `W-1`, as well as at middle splits. A design whose index arithmetic holds only for a power-of-two `LO` would fail at `LO` = 5 or 7.

// File: rtl/hybrid_prefix_adder.sv
module hybrid_prefix_adder #(
  parameter int W  = 16,
  parameter int LO = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int HI = W - LO;
  localparam int LB = (LO > 1) ? $clog2(LO) : 1;
  localparam int LK = (HI > 1) ? $clog2(HI) : 1;
  localparam int BF = 2 * LB - 1;

  if (LO < 1 || LO > W - 1) begin : g_bad_split
    $error("hybrid_prefix_adder: LO must lie in 1..W-1");
  end

  logic [W-1:0] g, p, c;
  logic         c_lo;
  assign g = a & b;
  assign p = a ^ b;

  logic [LO-1:0] bg [0:BF];
  logic [LO-1:0] bp [0:BF];

  for (genvar i = 0; i < LO; i++) begin : g_lo_seed
    if (i == 0) begin : g_b0
      assign bg[0][i] = g[0] | (p[0] & cin);
    end else begin : g_bn
      assign bg[0][i] = g[i];
    end
    assign bp[0][i] = p[i];
  end

  for (genvar l = 0; l < LB; l++) begin : g_up
    for (genvar i = 0; i < LO; i++) begin : g_node
      if ((i + 1) % (2 ** (l + 1)) == 0) begin : g_op
        assign bg[l+1][i] = bg[l][i] | (bp[l][i] & bg[l][i - 2**l]);
        assign bp[l+1][i] = bp[l][i] & bp[l][i - 2**l];
      end else begin : g_pass
        assign bg[l+1][i] = bg[l][i];
        assign bp[l+1][i] = bp[l][i];
      end
    end
  end

  for (genvar d = 0; d < LB - 1; d++) begin : g_down
    localparam int S = 2 ** (LB - 1 - d);
    for (genvar i = 0; i < LO; i++) begin : g_node
      if (((i + 1) % S == S / 2) && (i + 1 > S)) begin : g_op
        assign bg[LB+1+d][i] = bg[LB+d][i] | (bp[LB+d][i] & bg[LB+d][i - S/2]);
        assign bp[LB+1+d][i] = bp[LB+d][i] & bp[LB+d][i - S/2];
      end else begin : g_pass
        assign bg[LB+1+d][i] = bg[LB+d][i];
        assign bp[LB+1+d][i] = bp[LB+d][i];
      end
    end
  end

  assign c_lo = bg[BF][LO-1];

  for (genvar i = 0; i < LO; i++) begin : g_lo_carry
    if (i == 0) begin : g_c0
      assign c[i] = cin;
    end else begin : g_cn
      assign c[i] = bg[BF][i-1];
    end
  end

  logic [HI-1:0] kg [0:LK];
  logic [HI-1:0] kp [0:LK];

  for (genvar j = 0; j < HI; j++) begin : g_hi_seed
    if (j == 0) begin : g_k0
      assign kg[0][j] = g[LO] | (p[LO] & c_lo);
    end else begin : g_kn
      assign kg[0][j] = g[LO+j];
    end
    assign kp[0][j] = p[LO+j];
  end

  for (genvar k = 0; k < LK; k++) begin : g_ks
    for (genvar j = 0; j < HI; j++) begin : g_node
      if (j >= 2 ** k) begin : g_op
        assign kg[k+1][j] = kg[k][j] | (kp[k][j] & kg[k][j - 2**k]);
        assign kp[k+1][j] = kp[k][j] & kp[k][j - 2**k];
      end else begin : g_pass
        assign kg[k+1][j] = kg[k][j];
        assign kp[k+1][j] = kp[k][j];
      end
    end
  end

  for (genvar j = 0; j < HI; j++) begin : g_hi_carry
    if (j == 0) begin : g_c0
      assign c[LO] = c_lo;
    end else begin : g_cn
      assign c[LO+j] = kg[LK][j-1];
    end
  end

  assign sum  = p ^ c;
  assign cout = kg[LK][HI-1];
endmodule

// File: rtl/hybrid_prefix_adder_chk.sv
module hybrid_prefix_adder_chk #(
  parameter int W  = 16,
  parameter int LO = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         c_mid
);
  logic [W:0]  full;
  logic [LO:0] low;
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign low  = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]} + {{LO{1'b0}}, cin};

  always_comb begin
    p_exact_sum_r1: assert (sum == full[W-1:0]);
    p_carry_out_r2: assert (cout == full[W]);
    p_split_carry_r3: assert (c_mid == low[LO]);
    p_low_only_r4: assert (sum[LO-1:0] == low[LO-1:0]);
    if (b == '0 && !cin) begin
      p_zero_identity_r6: assert (sum == a && !cout);
    end
    if (b == ~a) begin
      p_full_propagate_r7: assert (sum == {W{~cin}} && cout == cin);
    end
  end
endmodule

bind hybrid_prefix_adder hybrid_prefix_adder_chk #(.W(W), .LO(LO)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .c_mid(c_lo)
);

// File: tb/hybrid_prefix_adder_test.sv
module hybrid_prefix_adder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8;
  logic [15:0] a16, b16;
  logic        ci;

  logic [7:0]  s8 [0:3];
  logic        o8 [0:3];
  logic [15:0] s16 [0:2];
  logic        o16 [0:2];

  hybrid_prefix_adder #(.W(8), .LO(4))  uut   (.a(a8), .b(b8), .cin(ci), .sum(s8[0]), .cout(o8[0]));
  hybrid_prefix_adder #(.W(8), .LO(1))  uut_1 (.a(a8), .b(b8), .cin(ci), .sum(s8[1]), .cout(o8[1]));
  hybrid_prefix_adder #(.W(8), .LO(7))  uut_7 (.a(a8), .b(b8), .cin(ci), .sum(s8[2]), .cout(o8[2]));
  hybrid_prefix_adder #(.W(8), .LO(5))  uut_5 (.a(a8), .b(b8), .cin(ci), .sum(s8[3]), .cout(o8[3]));
  hybrid_prefix_adder #(.W(16), .LO(8))  uut16a (.a(a16), .b(b16), .cin(ci), .sum(s16[0]), .cout(o16[0]));
  hybrid_prefix_adder #(.W(16), .LO(3))  uut16b (.a(a16), .b(b16), .cin(ci), .sum(s16[1]), .cout(o16[1]));
  hybrid_prefix_adder #(.W(16), .LO(15)) uut16c (.a(a16), .b(b16), .cin(ci), .sum(s16[2]), .cout(o16[2]));

  task automatic cmp(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: a8=%h b8=%h a16=%h b16=%h cin=%b got=%h exp=%h",
               tag, a8, b8, a16, b16, ci, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [8:0]  e8;
    logic [16:0] e16;
    #1;
    e8  = {1'b0, a8} + {1'b0, b8} + {8'd0, ci};
    e16 = {1'b0, a16} + {1'b0, b16} + {16'd0, ci};
    for (int k = 0; k < 4; k++) cmp(tag, {8'd0, o8[k], s8[k]}, {8'd0, e8});
    for (int k = 0; k < 3; k++) cmp(tag, {o16[k], s16[k]}, e16);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corner [0:7];
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; ci = 1'b0;
    corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'hAAAA; corner[3] = 16'h5555;
    corner[4] = 16'h00FF; corner[5] = 16'hFF00; corner[6] = 16'h8000; corner[7] = 16'h0001;

    check_all("R6 zero operands");

    // R1 R2 R5: exhaustive sweep at W=8 over four splits
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++) begin
          a8 = x[7:0]; b8 = y[7:0]; ci = c[0];
          a16 = {x[7:0], y[7:0]}; b16 = {y[7:0], x[7:0]};
          check_all("R1/R2 sweep");
        end

    // R1 R5: corner pairs at W=16
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          a16 = corner[x]; b16 = corner[y]; ci = c[0];
          a8 = corner[x][7:0]; b8 = corner[y][15:8];
          check_all("R5 corners");
        end

    // R1 R5: random operands at W=16
    for (int n = 0; n < 4000; n++) begin
      a16 = $urandom; b16 = $urandom; ci = $urandom;
      check_all("R1 random");
    end

    // R3: low part all ones plus one must carry into the high part
    a16 = 16'h00FF; b16 = 16'h0001; ci = 1'b0; #1;
    cmp("R3 split carry", {o16[0], s16[0]}, 17'h00100);
    a16 = 16'h7FFF; b16 = 16'h0000; ci = 1'b1; #1;
    cmp("R3 split carry LO=15", {o16[2], s16[2]}, 17'h08000);

    // R4: high operand bits do not disturb low sum bits
    a16 = 16'h0037; b16 = 16'h00A9; ci = 1'b1; #1;
    for (int h = 0; h < 256; h++) begin
      a16[15:8] = h[7:0]; b16[15:8] = ~h[7:0]; #1;
      cmp("R4 low independence", {9'd0, s16[0][7:0]}, {9'd0, 8'hE1});
      cmp("R4 low independence LO=3", {14'd0, s16[1][2:0]}, {14'd0, 3'b001});
    end

    // R6: b zero, cin zero gives a
    a16 = 16'hBEEF; b16 = 16'h0000; ci = 1'b0; #1;
    cmp("R6 identity", {o16[1], s16[1]}, {1'b0, 16'hBEEF});

    // R7: full propagation both ways
    for (int c = 0; c < 2; c++) begin
      a16 = 16'hA5C3; b16 = ~16'hA5C3; ci = c[0]; #1;
      for (int k = 0; k < 3; k++)
        cmp("R7 propagate", {o16[k], s16[k]}, c[0] ? 17'h10000 : 17'h0FFFF);
    end

    // R8: all ones plus all ones
    for (int c = 0; c < 2; c++) begin
      a16 = 16'hFFFF; b16 = 16'hFFFF; ci = c[0]; #1;
      for (int k = 0; k < 3; k++)
        cmp("R8 all ones", {o16[k], s16[k]}, {1'b1, 15'h7FFF, c[0]});
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule